// File: doc/BRIEF.md
# Parallel Bus Select Decoder

This block sits beside the CPU on a parallel expansion bus that carries up to eight add-on devices. It keeps a one-hot register that names the device currently selected, and it decodes the CPU address bus into chip enables. A 2 KB window at the top of the I/O area is steered either to the ROM of the selected device or, when no device is selected, to the built-in math ROM. A 512-byte shared RAM area is split into per-slot chip selects, and the cartridge hardware page just below it gets its own select.

The select register can only be written. Its address is shared with a read-only register that reports pending interrupts from external devices, and a second read-only address reports pending interrupts from internal devices. A write that sets more than one select bit is refused: no device is selected, the math ROM stays active, and a sticky error flag is raised until reset.

Top module: `pbus_sel_decoder`

## Requirements
- R1: Synchronous active-high reset clears the select register (`dev_sel` = 00h) and `sel_error`, so a window access after reset enables the math ROM.
- R2: A write (`wr_en`) to D1FFh whose data has exactly one bit set loads that value; from the next cycle `dev_sel` equals the written byte, bit n selecting device n.
- R3: A write of 00h to D1FFh deselects every device; from the next cycle window accesses enable the math ROM.
- R4: While `rd_en` or `wr_en` is high and the address is in D800h..DFFFh, `dev_rom_en` is high if any device is selected and `math_rom_en` is high otherwise; the two are never high together and both stay low outside the window or with no strobe.
- R5: A write to D1FFh with two or more bits set leaves `dev_sel` at 00h from the next cycle and sets `sel_error`, which stays set through later legal writes until reset.
- R6: A read (`rd_en`) of D1FFh drives `rdata` with `ext_irq_pend` and `rdata_valid` high, never with the select value.
- R7: A read of D1CFh drives `rdata` with `int_irq_pend` and `rdata_valid` high.
- R8: With a strobe, D600h..D61Fh asserts `slot_ram_sel[0]` and D620h..D63Fh asserts only `modem_ram_sel`; at most one of the slot, modem and cartridge selects is high.
- R9: With a strobe, slot n for n = 1..7 is selected over the 64 bytes starting at D600h + 64*n (D640h for slot 1, D7C0h for slot 7).
- R10: With a strobe, page D500h..D5FFh asserts `cart_io_sel` and no slot or modem select.
- R11: Writes to any address other than D1FFh, and reads of D1FFh, leave `dev_sel` unchanged.
- R12: When no status address is read, `rdata` is 00h and `rdata_valid` is low.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| ext_irq_pend | input | 8 | Pending interrupts, external devices |
| int_irq_pend | input | 8 | Pending interrupts, internal devices |
| dev_sel | output | 8 | One-hot device select (all zero = none) |
| math_rom_en | output | 1 | Math ROM enable for the window |
| dev_rom_en | output | 1 | Selected-device ROM enable for the window |
| slot_ram_sel | output | 8 | Per-slot shared RAM select |
| modem_ram_sel | output | 1 | Reserved modem RAM select |
| cart_io_sel | output | 1 | Cartridge hardware page select |
| rdata | output | 8 | Status read data |
| rdata_valid | output | 1 | Status read hit |
| sel_error | output | 1 | Sticky illegal-select flag |

## Verification
The read strobe and the write strobe can both be high on D1FFh in one cycle, so a status read and a select load land together. The bench drives such a cycle with interrupt bits that differ from the written select value, expects `rdata` to carry the interrupt bits in that cycle, and expects `dev_sel` to carry the new selection only in the following one. A window access in the cycle right after a select write is checked the same way, to confirm the ROM routing follows the register and not the write data.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int NUM_DEV = 8;
    localparam int AW      = 16;
    localparam int DW      = 8;

    // Fixed register addresses
    localparam logic [15:0] SEL_ADDR      = 16'hD1FF;
    localparam logic [15:0] INT_STAT_ADDR = 16'hD1CF;

    // Shared ROM window: 2 KB
    localparam logic [15:0] ROM_BASE      = 16'hD800;
    localparam int          ROM_SPAN_LOG2 = 11;

    // Shared RAM area: 512 bytes, 64-byte slots, slot 0 owns half a slot
    localparam logic [15:0] RAM_BASE      = 16'hD600;
    localparam int          RAM_SPAN_LOG2 = 9;
    localparam int          SLOT_LOG2     = 6;
    localparam int          SLOT0_LOG2    = 5;

    // Cartridge hardware page
    localparam logic [15:0] CART_BASE      = 16'hD500;
    localparam int          CART_SPAN_LOG2 = 8;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_INT  = 2'd2
    } stat_src_e;

    typedef struct packed {
        logic hit;
        logic legal;
    } sel_wr_t;

    function automatic int unsigned count_set(input logic [DW-1:0] v);
        int unsigned n;
        n = 0;
        for (int b = 0; b < DW; b++) begin
            n += int'(v[b]);
        end
        return n;
    endfunction

endpackage

// File: rtl/pbus_sel_reg.sv
module pbus_sel_reg
    import pbus_pkg::*;
#(
    parameter int N_DEV  = NUM_DEV,
    parameter int ADDR_W = AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_DEV-1:0]  wdata,
    input  logic              wr_en,
    output logic [N_DEV-1:0]  sel_q,
    output logic              err_q
);

    sel_wr_t wr_chk;

    always_comb begin
        wr_chk.hit   = wr_en && (addr == SEL_ADDR[ADDR_W-1:0]);
        wr_chk.legal = (count_set(wdata) <= 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            err_q <= 1'b0;
        end else if (wr_chk.hit) begin
            if (wr_chk.legal) begin
                sel_q <= wdata;
            end else begin
                sel_q <= '0;
                err_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pbus_rom_router.sv
module pbus_rom_router
    import pbus_pkg::*;
#(
    parameter int N_DEV  = NUM_DEV,
    parameter int ADDR_W = AW,
    parameter int SPAN   = ROM_SPAN_LOG2
) (
    input  logic [ADDR_W-1:SPAN] win_tag,
    input  logic                 access,
    input  logic [N_DEV-1:0]     sel,
    output logic                 math_en,
    output logic                 dev_en
);

    logic in_win;
    logic any_sel;

    always_comb begin
        in_win  = access && (win_tag == ROM_BASE[ADDR_W-1:SPAN]);
        any_sel = |sel;
        math_en = in_win && !any_sel;
        dev_en  = in_win && any_sel;
    end

endmodule

// File: rtl/pbus_ram_decoder.sv
module pbus_ram_decoder
    import pbus_pkg::*;
#(
    parameter int N_DEV  = NUM_DEV,
    parameter int ADDR_W = AW
) (
    input  logic [ADDR_W-1:SLOT0_LOG2] addr_hi,
    input  logic                       access,
    output logic [N_DEV-1:0]           slot_sel,
    output logic                       modem_sel,
    output logic                       cart_sel
);

    localparam int IDX_W = RAM_SPAN_LOG2 - SLOT_LOG2;

    logic             in_ram;
    logic [IDX_W-1:0] blk;
    logic             upper_half;

    always_comb begin
        in_ram     = access &&
                     (addr_hi[ADDR_W-1:RAM_SPAN_LOG2] == RAM_BASE[ADDR_W-1:RAM_SPAN_LOG2]);
        blk        = addr_hi[RAM_SPAN_LOG2-1:SLOT_LOG2];
        upper_half = addr_hi[SLOT0_LOG2];
        modem_sel  = in_ram && (blk == '0) && upper_half;
        cart_sel   = access &&
                     (addr_hi[ADDR_W-1:CART_SPAN_LOG2] == CART_BASE[ADDR_W-1:CART_SPAN_LOG2]);
    end

    for (genvar k = 0; k < N_DEV; k++) begin : g_slot
        if (k == 0) begin : g_half
            assign slot_sel[k] = in_ram && (blk == '0) && !upper_half;
        end else begin : g_full
            assign slot_sel[k] = in_ram && (blk == IDX_W'(k));
        end
    end

endmodule

// File: rtl/pbus_status_mux.sv
module pbus_status_mux
    import pbus_pkg::*;
#(
    parameter int ADDR_W = AW,
    parameter int DATA_W = DW
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] ext_pend,
    input  logic [DATA_W-1:0] int_pend,
    output logic [DATA_W-1:0] rdata,
    output logic              valid
);

    stat_src_e src;

    always_comb begin
        src = SRC_NONE;
        if (rd_en) begin
            if (addr == SEL_ADDR[ADDR_W-1:0]) begin
                src = SRC_EXT;
            end else if (addr == INT_STAT_ADDR[ADDR_W-1:0]) begin
                src = SRC_INT;
            end
        end
        unique case (src)
            SRC_EXT: rdata = ext_pend;
            SRC_INT: rdata = int_pend;
            default: rdata = '0;
        endcase
        valid = (src != SRC_NONE);
    end

endmodule

// File: rtl/pbus_sel_decoder.sv
module pbus_sel_decoder
    import pbus_pkg::*;
#(
    parameter int N_DEV  = NUM_DEV,
    parameter int ADDR_W = AW,
    parameter int DATA_W = DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [N_DEV-1:0]  ext_irq_pend,
    input  logic [N_DEV-1:0]  int_irq_pend,
    output logic [N_DEV-1:0]  dev_sel,
    output logic              math_rom_en,
    output logic              dev_rom_en,
    output logic [N_DEV-1:0]  slot_ram_sel,
    output logic              modem_ram_sel,
    output logic              cart_io_sel,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid,
    output logic              sel_error
);

    logic access;
    assign access = rd_en | wr_en;

    pbus_sel_reg #(.N_DEV(N_DEV), .ADDR_W(ADDR_W)) u_sel (
        .clk   (clk),
        .rst   (rst),
        .addr  (addr),
        .wdata (wdata[N_DEV-1:0]),
        .wr_en (wr_en),
        .sel_q (dev_sel),
        .err_q (sel_error)
    );

    pbus_rom_router #(.N_DEV(N_DEV), .ADDR_W(ADDR_W), .SPAN(ROM_SPAN_LOG2)) u_rom (
        .win_tag (addr[ADDR_W-1:ROM_SPAN_LOG2]),
        .access  (access),
        .sel     (dev_sel),
        .math_en (math_rom_en),
        .dev_en  (dev_rom_en)
    );

    pbus_ram_decoder #(.N_DEV(N_DEV), .ADDR_W(ADDR_W)) u_ram (
        .addr_hi   (addr[ADDR_W-1:SLOT0_LOG2]),
        .access    (access),
        .slot_sel  (slot_ram_sel),
        .modem_sel (modem_ram_sel),
        .cart_sel  (cart_io_sel)
    );

    pbus_status_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stat (
        .addr     (addr),
        .rd_en    (rd_en),
        .ext_pend (ext_irq_pend),
        .int_pend (int_irq_pend),
        .rdata    (rdata),
        .valid    (rdata_valid)
    );

endmodule

// File: rtl/pbus_sel_checker.sv
module pbus_sel_checker
    import pbus_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [15:0] addr,
    input logic [7:0]  wdata,
    input logic        rd_en,
    input logic        wr_en,
    input logic [7:0]  ext_irq_pend,
    input logic [7:0]  dev_sel,
    input logic        math_rom_en,
    input logic        dev_rom_en,
    input logic [7:0]  slot_ram_sel,
    input logic        modem_ram_sel,
    input logic        cart_io_sel,
    input logic [7:0]  rdata,
    input logic        sel_error
);

    // R1: leaving reset, nothing selected and no error
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (dev_sel == 8'h00 && !sel_error));

    // R2: legal write loads the written byte
    a_r2_legal_load: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == SEL_ADDR && $countones(wdata) == 1) |=> (dev_sel == $past(wdata)));

    // R5: illegal write leaves nothing selected and flags an error
    a_r5_illegal_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == SEL_ADDR && $countones(wdata) > 1) |=> (dev_sel == 8'h00 && sel_error));

    // R5: error flag is sticky
    a_r5_error_sticky: assert property (@(posedge clk) disable iff (rst)
        sel_error |=> sel_error);

    // R4: the two ROM enables never overlap, selection stays one-hot
    a_r4_rom_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(math_rom_en && dev_rom_en) && $onehot0(dev_sel));

    // R11: no select write means the selection holds
    a_r11_sel_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == SEL_ADDR) |=> $stable(dev_sel));

    // R6: status read at the shared address returns external pending bits
    a_r6_ext_status: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == SEL_ADDR) |-> (rdata == ext_irq_pend));

    // R8: at most one RAM / cartridge select at a time
    a_r8_ram_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({slot_ram_sel, modem_ram_sel, cart_io_sel}));

endmodule

bind pbus_sel_decoder pbus_sel_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .addr          (addr),
    .wdata         (wdata),
    .rd_en         (rd_en),
    .wr_en         (wr_en),
    .ext_irq_pend  (ext_irq_pend),
    .dev_sel       (dev_sel),
    .math_rom_en   (math_rom_en),
    .dev_rom_en    (dev_rom_en),
    .slot_ram_sel  (slot_ram_sel),
    .modem_ram_sel (modem_ram_sel),
    .cart_io_sel   (cart_io_sel),
    .rdata         (rdata),
    .sel_error     (sel_error)
);

// File: tb/sim_pbus_sel_decoder.sv
module sim_pbus_sel_decoder;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  ext_irq_pend = '0;
    logic [7:0]  int_irq_pend = '0;
    logic [7:0]  dev_sel;
    logic        math_rom_en;
    logic        dev_rom_en;
    logic [7:0]  slot_ram_sel;
    logic        modem_ram_sel;
    logic        cart_io_sel;
    logic [7:0]  rdata;
    logic        rdata_valid;
    logic        sel_error;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbus_sel_decoder u0 (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .rd_en(rd_en), .wr_en(wr_en),
        .ext_irq_pend(ext_irq_pend), .int_irq_pend(int_irq_pend),
        .dev_sel(dev_sel), .math_rom_en(math_rom_en), .dev_rom_en(dev_rom_en),
        .slot_ram_sel(slot_ram_sel), .modem_ram_sel(modem_ram_sel),
        .cart_io_sel(cart_io_sel), .rdata(rdata), .rdata_valid(rdata_valid),
        .sel_error(sel_error)
    );

    typedef struct {
        logic [29:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t    sb_q[$];
    int          n_checks = 0;
    int          n_errors = 0;
    logic [7:0]  m_sel = '0;
    logic        m_err = 1'b0;
    bit          finished = 0;

    function automatic logic [29:0] observed();
        return {dev_sel, math_rom_en, dev_rom_en, slot_ram_sel,
                modem_ram_sel, cart_io_sel, rdata, rdata_valid, sel_error};
    endfunction

    function automatic logic [29:0] predict(input logic [15:0] a, input logic rd,
                                            input logic wr, input logic [7:0] e,
                                            input logic [7:0] i);
        logic       acc, win, math, dev, modem, cart, vld;
        logic [7:0] slot, rd_d;
        int         off;
        acc   = rd | wr;
        win   = acc && (a >= 16'hD800);
        math  = win && (m_sel == 8'h00);
        dev   = win && (m_sel != 8'h00);
        slot  = '0;
        modem = 1'b0;
        if (acc && a >= 16'hD600 && a <= 16'hD7FF) begin
            off = int'(a) - 'hD600;
            if (off < 32)      slot[0] = 1'b1;
            else if (off < 64) modem   = 1'b1;
            else               slot[off / 64] = 1'b1;
        end
        cart = acc && (a >= 16'hD500) && (a <= 16'hD5FF);
        rd_d = 8'h00;
        vld  = 1'b0;
        if (rd && a == 16'hD1FF) begin rd_d = e; vld = 1'b1; end
        else if (rd && a == 16'hD1CF) begin rd_d = i; vld = 1'b1; end
        return {m_sel, math, dev, slot, modem, cart, rd_d, vld, m_err};
    endfunction

    // Driver: one bus cycle, expected result pushed for the monitor
    task automatic bus_cycle(input logic [15:0] a, input logic rd, input logic wr,
                             input logic [7:0] d, input logic [7:0] e,
                             input logic [7:0] i, input string tag);
        sb_item_t it;
        @(negedge clk);
        addr = a; rd_en = rd; wr_en = wr; wdata = d;
        ext_irq_pend = e; int_irq_pend = i;
        it.exp = predict(a, rd, wr, e, i);
        it.tag = tag;
        sb_q.push_back(it);
        if (wr && a == 16'hD1FF) begin
            if ($countones(d) <= 1) m_sel = d;
            else begin m_sel = 8'h00; m_err = 1'b1; end
        end
    endtask

    task automatic rd_at(input logic [15:0] a, input string tag);
        bus_cycle(a, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, tag);
    endtask

    task automatic wr_sel(input logic [7:0] d, input string tag);
        bus_cycle(16'hD1FF, 1'b0, 1'b1, d, 8'h00, 8'h00, tag);
    endtask

    // Monitor: compares a quarter period after the driving edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (sb_q.size() > 0) begin
                sb_item_t it;
                logic [29:0] act;
                it  = sb_q.pop_front();
                act = observed();
                n_checks++;
                if (act !== it.exp) begin
                    n_errors++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, window goes to math ROM
        rd_at(16'hD900, "R1 reset math rom");
        // R6: shared address reads external pending bits
        bus_cycle(16'hD1FF, 1'b1, 1'b0, 8'h00, 8'hA5, 8'h3C, "R6 ext status");
        // R7: internal status address
        bus_cycle(16'hD1CF, 1'b1, 1'b0, 8'h00, 8'hA5, 8'h3C, "R7 int status");
        // R2: select device 2
        wr_sel(8'h04, "R2 write select 04");
        rd_at(16'hDABC, "R2 R4 device rom after select");
        // R11: write elsewhere and read of select address do not change it
        bus_cycle(16'hD1FE, 1'b0, 1'b1, 8'hFF, 8'h00, 8'h00, "R11 write other addr");
        bus_cycle(16'hD1FF, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, "R6 R11 read not select value");
        rd_at(16'hD800, "R11 select held");
        // R2 / R4: device 7, window edges
        wr_sel(8'h80, "R2 write select 80");
        rd_at(16'hDFFF, "R4 window top");
        rd_at(16'hD7FF, "R4 R9 below window");
        // R8: slot 0 and modem hole
        rd_at(16'hD600, "R8 slot0 start");
        rd_at(16'hD61F, "R8 slot0 end");
        rd_at(16'hD620, "R8 modem start");
        bus_cycle(16'hD63F, 1'b0, 1'b1, 8'h11, 8'h00, 8'h00, "R8 modem end write");
        // R9: every full slot, both edges
        for (int n = 1; n < 8; n++) begin
            rd_at(16'hD600 + 16'(64 * n), "R9 slot start");
            rd_at(16'hD600 + 16'(64 * n + 63), "R9 slot end");
        end
        // R10: cartridge page
        rd_at(16'hD500, "R10 cart start");
        rd_at(16'hD5FF, "R10 cart end");
        rd_at(16'hD4FF, "R10 below cart");
        // R3: deselect
        wr_sel(8'h00, "R3 write zero");
        rd_at(16'hD800, "R3 math rom back");
        // R12: no status hit, and no strobe
        rd_at(16'hD200, "R12 unrelated read");
        bus_cycle(16'hD800, 1'b0, 1'b0, 8'h00, 8'hFF, 8'hFF, "R4 R12 no strobe");
        // Same cycle: status read and select write on D1FF
        bus_cycle(16'hD1FF, 1'b1, 1'b1, 8'h02, 8'h5A, 8'h00, "R2 R6 read+write same cycle");
        rd_at(16'hD900, "R2 new select visible next cycle");
        // R5: illegal write, then legal write keeps flag
        wr_sel(8'h03, "R5 illegal write");
        rd_at(16'hD900, "R5 math rom after illegal");
        wr_sel(8'h10, "R5 legal after illegal");
        rd_at(16'hDC00, "R5 error sticky");
        wr_sel(8'hFF, "R5 all bits");
        rd_at(16'hD800, "R5 cleared again");

        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule